// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a two-wire serial slave. It gives a host read and write access to a small bank of 8-bit configuration registers, and the whole bank is also driven out in parallel to the logic that uses those settings. The slave watches SCL and SDA with a fast system clock. It drives SDA only through an open-drain pull-low enable and never holds SCL.

A block write names a starting index and then a byte count, and the data bytes for consecutive registers follow. A block read first sets the index with a short write phase and then switches direction with a repeated start. The slave answers with a byte count taken from a dedicated count register, followed by the registers in ascending order. The host writes the count register like any other register, so it controls how long a read is.

Top module: `smb_idx_slave`

## Requirements
- R1: After reset, registers 0 to 7 read 00h, register 8 (the read count register) reads 08h, and `sda_oe_o` is 0.
- R2: The slave acknowledges only address bytes D4h (write) and D5h (read), which share the 7-bit address 6Ah with R/W in bit 0. Any other address gets no acknowledge, and every byte up to the next start or stop is ignored: no acknowledge and no register change.
- R3: A block write sends the address, then index N, then count X, then data bytes. Each byte is acknowledged, and data byte i lands in register N+i, which is visible on `reg_bank_o` (register k in bits 8k+7..8k) from the ACK clock of that byte onward.
- R4: In a block read (write phase with D4h and index N, repeated start, D5h), the first byte returned is the current value of register 8. Registers N, N+1, … follow, most significant bit first.
- R5: Writing register 8 changes the count byte that later block reads return first.
- R6: A data byte whose target index is 9 or above is acknowledged and discarded. A read of index 9 or above returns 00h.
- R7: Data bytes beyond the count X of a block write are not acknowledged and are discarded, and the slave ignores the bus until the next start or stop.
- R8: A start or repeated start that arrives partway through a byte drops that byte, and the next eight bits are taken as a fresh address byte.
- R9: `sda_oe_o` changes only while SCL is low.
- R10: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next start. A stop always returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_bank_o | output | 72 | All registers in parallel, register k in bits 8k+7..8k |

## Verification
On a single SCL falling edge the slave decides whether to acknowledge a completed data byte and also whether to commit that byte to the register bank. The two outcomes must agree: an acknowledged in-range byte is written, an acknowledged out-of-range byte is not, and an over-count byte is neither. The bench provokes all three cases by sending one data byte more than the stated count and by aiming writes at indices past the bank. In each case it judges the acknowledge bit it sampled on the bus against the register contents on `reg_bank_o` after the stop.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKRX,
        ST_TX,
        ST_TXACK,
        ST_IGNORE
    } state_t;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_INDEX,
        ROLE_COUNT,
        ROLE_DATA
    } role_t;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/smb_bus_monitor.sv
module smb_bus_monitor
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev_o.sda   = sda_s;
        ev_o.rise  = scl_s & ~scl_q;
        ev_o.fall  = ~scl_s & scl_q;
        ev_o.start = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_pkg::*;
#(
    parameter int          NREG    = 9,
    parameter int          CNT_IDX = 8,
    parameter logic [7:0]  CNT_RST = 8'd8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [BYTE_W-1:0]      wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic [BYTE_W-1:0]      rd_idx,
    output logic [BYTE_W-1:0]      rd_data,
    output logic [BYTE_W-1:0]      cnt_o,
    output logic [NREG*BYTE_W-1:0] bank_o
);
    localparam int IDX_W = $clog2(NREG);

    logic [BYTE_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] RST_VAL = (g == CNT_IDX) ? CNT_RST : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == BYTE_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
        assign bank_o[g*BYTE_W +: BYTE_W] = regs[g];
    end

    always_comb begin
        if (rd_idx < BYTE_W'(NREG)) begin
            rd_data = regs[rd_idx[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

    assign cnt_o = regs[CNT_IDX];
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave
    import smb_pkg::*;
#(
    parameter int          NREG     = 9,
    parameter int          CNT_IDX  = 8,
    parameter logic [7:0]  CNT_RST  = 8'd8,
    parameter logic [6:0]  DEV_ADDR = 7'h6A
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    output logic [NREG*BYTE_W-1:0] reg_bank_o
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    bus_ev_t           ev;
    state_t            state;
    role_t             role;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] idx;
    logic [BYTE_W-1:0] wr_left;
    logic              reading;
    logic              host_ack;
    logic              start_det;
    logic              byte_done;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] cnt_val;

    smb_bus_monitor #(.SYNC_STAGES(2)) i_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    smb_reg_bank #(
        .NREG    (NREG),
        .CNT_IDX (CNT_IDX),
        .CNT_RST (CNT_RST)
    ) i_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (shreg),
        .rd_idx  (idx),
        .rd_data (rd_data),
        .cnt_o   (cnt_val),
        .bank_o  (reg_bank_o)
    );

    assign start_det = ev.start;
    assign byte_done = (state == ST_RX) && ev.fall && (bit_cnt == CNT_W'(BYTE_W))
                       && !ev.start && !ev.stop;
    assign wr_en     = byte_done && (role == ROLE_DATA) && (wr_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            role     <= ROLE_ADDR;
            bit_cnt  <= '0;
            shreg    <= '0;
            idx      <= '0;
            wr_left  <= '0;
            reading  <= 1'b0;
            host_ack <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (ev.stop) begin
            state    <= ST_IDLE;
            reading  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_RX;
            role     <= ROLE_ADDR;
            bit_cnt  <= '0;
            reading  <= 1'b0;
            sda_oe_o <= 1'b0;
        end else begin
            unique case (state)
                ST_RX: begin
                    if (ev.rise) begin
                        shreg   <= {shreg[BYTE_W-2:0], ev.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        unique case (role)
                            ROLE_ADDR: begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    reading  <= shreg[0];
                                    role     <= ROLE_INDEX;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACKRX;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                            ROLE_INDEX: begin
                                idx      <= shreg;
                                role     <= ROLE_COUNT;
                                sda_oe_o <= 1'b1;
                                state    <= ST_ACKRX;
                            end
                            ROLE_COUNT: begin
                                wr_left  <= shreg;
                                role     <= ROLE_DATA;
                                sda_oe_o <= 1'b1;
                                state    <= ST_ACKRX;
                            end
                            ROLE_DATA: begin
                                if (wr_left != '0) begin
                                    idx      <= idx + 1'b1;
                                    wr_left  <= wr_left - 1'b1;
                                    sda_oe_o <= 1'b1;
                                    state    <= ST_ACKRX;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                            default: state <= ST_IGNORE;
                        endcase
                    end
                end
                ST_ACKRX: begin
                    if (ev.fall) begin
                        bit_cnt <= '0;
                        if (reading) begin
                            shreg    <= cnt_val;
                            sda_oe_o <= ~cnt_val[BYTE_W-1];
                            state    <= ST_TX;
                        end else begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (ev.fall) begin
                        if (bit_cnt == CNT_W'(BYTE_W)) begin
                            sda_oe_o <= 1'b0;
                            state    <= ST_TXACK;
                        end else begin
                            shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe_o <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_TXACK: begin
                    if (ev.rise) begin
                        host_ack <= ~ev.sda;
                    end else if (ev.fall) begin
                        if (host_ack) begin
                            shreg    <= rd_data;
                            sda_oe_o <= ~rd_data[BYTE_W-1];
                            idx      <= idx + 1'b1;
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else begin
                            reading <= 1'b0;
                            state   <= ST_IGNORE;
                        end
                    end
                end
                ST_IGNORE: sda_oe_o <= 1'b0;
                default:   sda_oe_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/smb_idx_slave_chk.sv
module smb_idx_slave_chk
    import smb_pkg::*;
#(
    parameter int NREG = 9
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   scl_i,
    input logic                   sda_oe_o,
    input logic [NREG*BYTE_W-1:0] reg_bank_o,
    input state_t                 state,
    input logic [3:0]             bit_cnt,
    input logic                   wr_en,
    input logic                   start_det
);
    // R9: the pull-low enable moves only while SCL is low
    a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);

    // R10: idle slave never holds SDA
    a_r10_idle_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R2: ignoring slave never holds SDA
    a_r2_ignore_release: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe_o);

    // R3: every committed byte is acknowledged
    a_r3_write_acked: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_oe_o);

    // R6: register outputs hold unless a write strobe was issued
    a_r6_bank_stable: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(reg_bank_o));

    // R8: a start rearms address reception from bit zero
    a_r8_start_rearm: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_RX) && (bit_cnt == 4'd0));
endmodule

bind smb_idx_slave smb_idx_slave_chk #(.NREG(NREG)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .reg_bank_o (reg_bank_o),
    .state      (state),
    .bit_cnt    (bit_cnt),
    .wr_en      (wr_en),
    .start_det  (start_det)
);

// File: tb/test_smb_idx_slave.sv
`timescale 1ns/1ps
module test_smb_idx_slave;
    localparam int NREG = 9;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_oe_o;
    logic [NREG*8-1:0] reg_bank_o;
    wire  sda_line = sda_drv & ~sda_oe_o;

    always #2.5 clk = ~clk;

    smb_idx_slave i_smb_idx_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_drv),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe_o),
        .reg_bank_o (reg_bank_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int r9_viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] shadow [NREG];
    logic [7:0] wbuf [16];
    logic       abuf [20];
    logic [7:0] rbuf [16];

    // index N, count X, data seed
    localparam logic [23:0] VEC [4] = '{24'h00_03_11, 24'h04_04_A0,
                                        24'h02_02_5C, 24'h07_01_03};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; hold();
        scl_drv = 1'b1; hold();
        sda_drv = 1'b0; hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; hold();
        scl_drv = 1'b1; hold();
        sda_drv = 1'b1; hold();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; hold();
        scl_drv = 1'b1; hold(); hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; hold();
        scl_drv = 1'b1; hold();
        ack = ~sda_line; hold();
        scl_drv = 1'b0; hold();
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold();
            scl_drv = 1'b1; hold();
            b[i] = sda_line; hold();
            scl_drv = 1'b0;
        end
        hold();
        sda_drv = ~give_ack;
        scl_drv = 1'b1; hold(); hold();
        scl_drv = 1'b0; hold();
        sda_drv = 1'b1;
    endtask

    task automatic block_write(input logic [7:0] n_idx, input logic [7:0] cnt, input int n);
        logic a;
        bus_start();
        wr_byte(8'hD4, a); abuf[0] = a;
        wr_byte(n_idx, a); abuf[1] = a;
        wr_byte(cnt, a);   abuf[2] = a;
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], a);
            abuf[3+i] = a;
        end
        bus_stop();
        for (int i = 0; i < n && i < int'(cnt); i++)
            if (int'(n_idx) + i < NREG) shadow[int'(n_idx) + i] = wbuf[i];
    endtask

    task automatic block_read(input logic [7:0] n_idx, input int n);
        logic a;
        logic [7:0] b;
        bus_start();
        wr_byte(8'hD4, a); chk("R2 write address ack", a, 1);
        wr_byte(n_idx, a); chk("R4 index ack", a, 1);
        bus_start();
        wr_byte(8'hD5, a); chk("R2 read address ack", a, 1);
        for (int i = 0; i <= n; i++) begin
            rd_byte(i < n, b);
            rbuf[i] = b;
        end
        bus_stop();
    endtask

    function automatic logic [7:0] model_rd(input int k);
        return (k < NREG) ? shadow[k] : 8'h00;
    endfunction

    task automatic chk_bank(input string req);
        for (int k = 0; k < NREG; k++) chk(req, reg_bank_o[k*8 +: 8], shadow[k]);
    endtask

    always @(negedge clk) begin
        if (!rst && (sda_oe_o !== oe_prev) && scl_drv) r9_viol++;
        oe_prev <= sda_oe_o;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] nidx, ncnt, seed;
        for (int k = 0; k < NREG; k++) shadow[k] = (k == 8) ? 8'h08 : 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        hold();

        // R1 reset state
        chk_bank("R1 reset value");
        chk("R1 sda released", sda_oe_o, 0);

        // R2 foreign address ignored until stop
        bus_start();
        wr_byte(8'hA0, a); chk("R2 foreign address nack", a, 0);
        wr_byte(8'h01, a); chk("R2 following byte ignored", a, 0);
        bus_stop();
        chk_bank("R2 bank untouched");

        // table of block writes and readbacks
        for (int v = 0; v < 4; v++) begin
            {nidx, ncnt, seed} = VEC[v];
            for (int i = 0; i < int'(ncnt); i++) wbuf[i] = seed + 8'(i * 19);
            block_write(nidx, ncnt, int'(ncnt));
            for (int i = 0; i < 3 + int'(ncnt); i++) chk("R3 write byte ack", abuf[i], 1);
            chk_bank("R3 register contents");
            block_read(nidx, int'(shadow[8]));
            chk("R4 count byte first", rbuf[0], shadow[8]);
            for (int i = 0; i < int'(shadow[8]); i++)
                chk("R4 R6 read data", rbuf[i+1], model_rd(int'(nidx) + i));
        end

        // R5 count register rewritten
        wbuf[0] = 8'h03;
        block_write(8'd8, 8'd1, 1);
        chk("R5 count write ack", abuf[3], 1);
        block_read(8'd1, 3);
        chk("R5 new count returned", rbuf[0], 8'h03);
        for (int i = 0; i < 3; i++) chk("R5 read data", rbuf[i+1], shadow[1+i]);

        // R6 out-of-bank writes acknowledged, discarded
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        block_write(8'd9, 8'd2, 2);
        chk("R6 beyond bank ack", abuf[3], 1);
        chk("R6 beyond bank ack", abuf[4], 1);
        chk_bank("R6 bank unchanged");
        block_read(8'd7, 3);
        chk("R6 read beyond bank", rbuf[3], 8'h00);

        // R7 extra data byte beyond count
        wbuf[0] = 8'h42; wbuf[1] = 8'h99;
        block_write(8'd0, 8'd1, 2);
        chk("R7 in-count ack", abuf[3], 1);
        chk("R7 over-count nack", abuf[4], 0);
        chk_bank("R7 bank contents");

        // R8 start in the middle of a byte
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        wbuf[0] = 8'h6B;
        block_write(8'd5, 8'd1, 1);
        chk("R8 address after abort ack", abuf[0], 1);
        chk_bank("R8 write after abort");

        // R10 host nack releases the bus
        bus_start();
        wr_byte(8'hD4, a);
        wr_byte(8'd0, a);
        bus_start();
        wr_byte(8'hD5, a);
        rd_byte(1'b0, rbuf[0]);
        chk("R10 count byte before nack", rbuf[0], shadow[8]);
        rd_byte(1'b0, rbuf[1]);
        chk("R10 line released after nack", rbuf[1], 8'hFF);
        bus_stop();
        chk("R10 idle after stop", sda_oe_o, 0);

        chk("R9 sda changes with scl high", r9_viol, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule